// File: doc/BRIEF.md
# Shared-Sense-Amp Bank State Tracker

This block keeps the open or closed state of a set of DRAM banks whose neighbours share sense amplifiers. A controller feeds it one decoded command per cycle, made of an opcode, a bank index, a row and a byte-mask flag. For each command the block reports one cycle later whether the command was legal. Legal commands update the bank state. Illegal commands are ignored.

Banks are split into two groups of sixteen. Inside a group, each bank shares a sense amplifier with the bank on either side of it. No sharing crosses from bank 15 to bank 16, and none exists beyond bank 0 or bank 31. An activate succeeds only when the target bank and every bank it shares with are closed. A bank can be closed in three ways: a row-packet precharge, an auto-precharge column command, or an extended precharge that must immediately follow a suitable column command.

The block also gives a vector of the banks that are open, and a lookup port that returns the row held by any bank.

Top module: `bank_state_tracker`

## Requirements
- R1: Each cycle with `cmd_valid_i` high is followed one clock later by `result_valid_o` high. `result_legal_o` then holds that command's verdict. A cycle without a command gives `result_valid_o` low one clock later.
- R2: The opcode encoding on `cmd_op_i` is: 0 extended precharge, 1 activate, 2 row precharge, 3 read, 4 write, 5 precharge-only column command, 6 read with precharge, 7 write with precharge.
- R3: An activate is legal only when the target bank is closed and every sharing neighbour is closed. Bank b shares with b-1 and with b+1, except across the 15/16 boundary and past banks 0 and 31. Two sharing banks are never open together.
- R4: A legal activate sets the target's bit in `open_vec_o` (bit index equals bank index). It also records `cmd_row_i` as that bank's row.
- R5: A row precharge is always legal. It closes the target bank. On a bank that is already closed it is a no-op.
- R6: A precharge-only column command is always legal and closes the bank. Read with precharge and write with precharge are legal only on an open bank, and they close it.
- R7: A read or write is legal only on an open bank. It never changes the open state.
- R8: An extended precharge is legal only when the immediately preceding valid command was a legal read, or a legal write with `cmd_mask_i` low, to the same bank. It then closes the bank. In every other case it is illegal.
- R9: While `rst_ni` is low, all banks are closed and `result_valid_o` and `result_legal_o` are low.
- R10: An illegal command, or a cycle with no command, leaves `open_vec_o` unchanged.
- R11: `query_open_o` and `query_row_o` combinationally show the state of bank `query_bank_i`. The row reads as zero when the bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Opcode (see R2) |
| cmd_bank_i | input | 5 | Target bank |
| cmd_row_i | input | 9 | Row for activate |
| cmd_mask_i | input | 1 | Write used a byte mask |
| query_bank_i | input | 5 | Bank to look up |
| result_valid_o | output | 1 | Verdict present |
| result_legal_o | output | 1 | Previous command was legal |
| open_vec_o | output | 32 | Per-bank open flags |
| query_open_o | output | 1 | Looked-up bank is open |
| query_row_o | output | 9 | Row held by looked-up bank |

## Verification
The verdict and the new open vector both appear one clock after the command. The bench therefore drives each command on a falling edge and checks the results on the next falling edge, after exactly one rising edge. The lookup port is combinational from the bank state. The bench sets the lookup bank equal to the command bank, so the same sample shows the row just written or just cleared. The extended-precharge rule depends on the previous command. For that reason the bench reference model keeps the pairing state across consecutive commands, including commands that are rejected.

// File: rtl/bst_pkg.sv
package bst_pkg;
  localparam int NUM_BANKS_D   = 32;
  localparam int GROUP_BANKS_D = 16;
  localparam int ROW_W_D       = 9;

  typedef enum logic [2:0] {
    OP_XPRE = 3'd0,
    OP_ACT  = 3'd1,
    OP_PRER = 3'd2,
    OP_RD   = 3'd3,
    OP_WR   = 3'd4,
    OP_PREC = 3'd5,
    OP_RDA  = 3'd6,
    OP_WRA  = 3'd7
  } op_e;

  typedef struct packed {
    logic legal;
    logic set_open;
    logic clr_open;
    logic arm;
  } verdict_t;
endpackage

// File: rtl/bst_share_map.sv
module bst_share_map #(
  parameter int NUM_BANKS   = bst_pkg::NUM_BANKS_D,
  parameter int GROUP_BANKS = bst_pkg::GROUP_BANKS_D
) (
  input  logic [NUM_BANKS-1:0] open_vec_i,
  output logic [NUM_BANKS-1:0] busy_vec_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic lo_busy, hi_busy;
    if ((b % GROUP_BANKS) != 0) begin : g_lo
      assign lo_busy = open_vec_i[b-1];
    end else begin : g_no_lo
      assign lo_busy = 1'b0;
    end
    if (((b % GROUP_BANKS) != GROUP_BANKS - 1) && (b != NUM_BANKS - 1)) begin : g_hi
      assign hi_busy = open_vec_i[b+1];
    end else begin : g_no_hi
      assign hi_busy = 1'b0;
    end
    assign busy_vec_o[b] = open_vec_i[b] | lo_busy | hi_busy;
  end
endmodule

// File: rtl/bst_cmd_decode.sv
module bst_cmd_decode
  import bst_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic       mask_i,
  input  logic       bank_open_i,
  input  logic       bank_busy_i,
  input  logic       arm_hit_i,
  output verdict_t   verdict_o
);
  verdict_t v;

  always_comb begin
    v = '0;
    unique case (op_e'(op_i))
      OP_ACT: begin
        v.legal    = !bank_busy_i;
        v.set_open = !bank_busy_i;
      end
      OP_PRER, OP_PREC: begin
        v.legal    = 1'b1;
        v.clr_open = bank_open_i;
      end
      OP_RD: begin
        v.legal = bank_open_i;
        v.arm   = bank_open_i;
      end
      OP_WR: begin
        v.legal = bank_open_i;
        v.arm   = bank_open_i & !mask_i;
      end
      OP_RDA, OP_WRA: begin
        v.legal    = bank_open_i;
        v.clr_open = bank_open_i;
      end
      OP_XPRE: begin
        v.legal    = arm_hit_i & bank_open_i;
        v.clr_open = arm_hit_i & bank_open_i;
      end
      default: v = '0;
    endcase
    verdict_o = valid_i ? v : '0;
  end
endmodule

// File: rtl/bst_bank_file.sv
module bst_bank_file #(
  parameter int NUM_BANKS = bst_pkg::NUM_BANKS_D,
  parameter int ROW_W     = bst_pkg::ROW_W_D,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [BANK_W-1:0]    query_bank_i,
  output logic [NUM_BANKS-1:0] open_vec_o,
  output logic                 query_open_o,
  output logic [ROW_W-1:0]     query_row_o
);
  logic [ROW_W-1:0] row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_vec_o[b] <= 1'b0;
        row_q[b]      <= '0;
      end else if (set_i && sel) begin
        open_vec_o[b] <= 1'b1;
        row_q[b]      <= row_i;
      end else if (clr_i && sel) begin
        open_vec_o[b] <= 1'b0;
      end
    end
  end

  assign query_open_o = open_vec_o[query_bank_i];
  assign query_row_o  = query_open_o ? row_q[query_bank_i] : '0;
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
  import bst_pkg::*;
#(
  parameter int NUM_BANKS   = bst_pkg::NUM_BANKS_D,
  parameter int GROUP_BANKS = bst_pkg::GROUP_BANKS_D,
  parameter int ROW_W       = bst_pkg::ROW_W_D,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [BANK_W-1:0]    cmd_bank_i,
  input  logic [ROW_W-1:0]     cmd_row_i,
  input  logic                 cmd_mask_i,
  input  logic [BANK_W-1:0]    query_bank_i,
  output logic                 result_valid_o,
  output logic                 result_legal_o,
  output logic [NUM_BANKS-1:0] open_vec_o,
  output logic                 query_open_o,
  output logic [ROW_W-1:0]     query_row_o
);
  logic [NUM_BANKS-1:0] busy_vec;
  logic                 arm_q;
  logic [BANK_W-1:0]    arm_bank_q;
  logic                 arm_hit;
  verdict_t             verdict;

  bst_share_map #(
    .NUM_BANKS  (NUM_BANKS),
    .GROUP_BANKS(GROUP_BANKS)
  ) u_share (
    .open_vec_i(open_vec_o),
    .busy_vec_o(busy_vec)
  );

  assign arm_hit = arm_q && (arm_bank_q == cmd_bank_i);

  bst_cmd_decode u_decode (
    .valid_i    (cmd_valid_i),
    .op_i       (cmd_op_i),
    .mask_i     (cmd_mask_i),
    .bank_open_i(open_vec_o[cmd_bank_i]),
    .bank_busy_i(busy_vec[cmd_bank_i]),
    .arm_hit_i  (arm_hit),
    .verdict_o  (verdict)
  );

  bst_bank_file #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
  ) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (verdict.set_open),
    .clr_i       (verdict.clr_open),
    .bank_i      (cmd_bank_i),
    .row_i       (cmd_row_i),
    .query_bank_i(query_bank_i),
    .open_vec_o  (open_vec_o),
    .query_open_o(query_open_o),
    .query_row_o (query_row_o)
  );

  // extended precharge pairs only with the command right before it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q          <= 1'b0;
      arm_bank_q     <= '0;
      result_valid_o <= 1'b0;
      result_legal_o <= 1'b0;
    end else begin
      result_valid_o <= cmd_valid_i;
      result_legal_o <= verdict.legal;
      if (cmd_valid_i) begin
        arm_q      <= verdict.arm;
        arm_bank_q <= cmd_bank_i;
      end
    end
  end
endmodule

// File: rtl/bst_checker.sv
module bst_checker
  import bst_pkg::*;
#(
  parameter int NUM_BANKS   = bst_pkg::NUM_BANKS_D,
  parameter int GROUP_BANKS = bst_pkg::GROUP_BANKS_D,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [2:0]           cmd_op_i,
  input logic [BANK_W-1:0]    cmd_bank_i,
  input logic                 result_valid_o,
  input logic                 result_legal_o,
  input logic [NUM_BANKS-1:0] open_vec_o
);
  logic adj_viol;
  always_comb begin
    adj_viol = 1'b0;
    for (int b = 0; b < NUM_BANKS - 1; b++)
      if (((b + 1) % GROUP_BANKS) != 0)
        adj_viol = adj_viol | (open_vec_o[b] & open_vec_o[b+1]);
  end

  logic is_act, is_prer, is_auto, is_rw;
  assign is_act  = cmd_valid_i && (cmd_op_i == OP_ACT);
  assign is_prer = cmd_valid_i && (cmd_op_i == OP_PRER);
  assign is_auto = cmd_valid_i && (cmd_op_i == OP_PREC || cmd_op_i == OP_RDA || cmd_op_i == OP_WRA);
  assign is_rw   = cmd_valid_i && (cmd_op_i == OP_RD || cmd_op_i == OP_WR);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> result_valid_o); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !result_valid_o); // R1
  AST_NO_ADJ_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adj_viol); // R3
  AST_ACT_OPEN_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && open_vec_o[cmd_bank_i]) |=> !result_legal_o); // R3
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |=> (!result_legal_o || open_vec_o[$past(cmd_bank_i)])); // R4
  AST_PRER_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_prer |=> (result_legal_o && !open_vec_o[$past(cmd_bank_i)])); // R5
  AST_AUTO_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_auto |=> !open_vec_o[$past(cmd_bank_i)]); // R6
  AST_RW_CLOSED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rw && !open_vec_o[cmd_bank_i]) |=> !result_legal_o); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(open_vec_o)); // R10
  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i != OP_ACT) |=> (result_legal_o || $stable(open_vec_o))); // R10
endmodule

bind bank_state_tracker bst_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .GROUP_BANKS(GROUP_BANKS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_op_i      (cmd_op_i),
  .cmd_bank_i    (cmd_bank_i),
  .result_valid_o(result_valid_o),
  .result_legal_o(result_legal_o),
  .open_vec_o    (open_vec_o)
);

// File: tb/bank_state_tracker_tb.sv
module bank_state_tracker_tb;
  import bst_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int RANDOM_CMDS = 4000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [4:0] cmd_bank_i = '0;
  logic [8:0] cmd_row_i = '0;
  logic       cmd_mask_i = 1'b0;
  logic [4:0] query_bank_i = '0;
  logic       result_valid_o, result_legal_o, query_open_o;
  logic [NB-1:0] open_vec_o;
  logic [8:0] query_row_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NB-1:0] m_open;
  logic [8:0]    m_row [NB];
  bit            m_arm;
  logic [4:0]    m_arm_bank;

  bank_state_tracker u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit busy(input int b);
    bit r = m_open[b];
    if ((b % 16) != 0)  r = r | m_open[b-1];
    if ((b % 16) != 15) r = r | m_open[b+1];
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      OP_ACT:  return "R3";
      OP_PRER: return "R5";
      OP_RD, OP_WR: return "R7";
      OP_PREC, OP_RDA, OP_WRA: return "R6";
      default: return "R8";
    endcase
  endfunction

  // model: returns expected verdict and updates the state (R2 encoding)
  function automatic bit model(input logic [2:0] op, input logic [4:0] b, input logic [8:0] row, input logic m);
    bit legal = 1'b0, nxt_arm = 1'b0;
    case (op)
      OP_ACT:  begin legal = !busy(b); if (legal) begin m_open[b] = 1'b1; m_row[b] = row; end end
      OP_PRER, OP_PREC: begin legal = 1'b1; m_open[b] = 1'b0; end
      OP_RD:   begin legal = m_open[b]; nxt_arm = legal; end
      OP_WR:   begin legal = m_open[b]; nxt_arm = legal && !m; end
      OP_RDA, OP_WRA: begin legal = m_open[b]; m_open[b] = 1'b0; end
      default: begin legal = m_arm && m_arm_bank == b && m_open[b]; if (legal) m_open[b] = 1'b0; end
    endcase
    m_arm = nxt_arm;
    m_arm_bank = b;
    return legal;
  endfunction

  task automatic issue(input bit v, input logic [2:0] op, input logic [4:0] b, input logic [8:0] row, input logic m);
    bit exp_legal = 1'b0;
    string t = tag_of(op);
    cmd_valid_i = v; cmd_op_i = op; cmd_bank_i = b; cmd_row_i = row; cmd_mask_i = m;
    query_bank_i = b;
    if (v) exp_legal = model(op, b, row, m);
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check("R1", "result_valid", 32'(result_valid_o), 32'(v));
    if (v) check(t, "legal", 32'(result_legal_o), 32'(exp_legal));
    check("R10", "open_vec", open_vec_o, m_open);
    check("R11", "query_open", 32'(query_open_o), 32'(m_open[b]));
    check(op == OP_ACT ? "R4" : "R11", "query_row", 32'(query_row_o), m_open[b] ? 32'(m_row[b]) : 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_open = '0; m_arm = 1'b0; m_arm_bank = '0;
    for (int i = 0; i < NB; i++) m_row[i] = '0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R9", "reset open_vec", open_vec_o, 32'd0);
    check("R9", "reset valid", 32'(result_valid_o), 32'd0);
    check("R9", "reset legal", 32'(result_legal_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    issue(1, OP_ACT, 5'd15, 9'd5, 0);   // R3 edge bank
    issue(1, OP_ACT, 5'd16, 9'd7, 0);   // R3 no sharing across 15/16
    issue(1, OP_ACT, 5'd14, 9'd1, 0);   // R3 neighbour open
    issue(1, OP_ACT, 5'd17, 9'd1, 0);   // R3
    issue(1, OP_ACT, 5'd15, 9'd9, 0);   // R3 already open
    issue(0, OP_ACT, 5'd15, 9'd0, 0);   // R1 idle
    issue(1, OP_PRER, 5'd15, 9'd0, 0);  // R5
    issue(1, OP_PRER, 5'd15, 9'd0, 0);  // R5 closed no-op
    issue(1, OP_ACT, 5'd14, 9'd511, 0); // R4
    issue(1, OP_RD, 5'd14, 9'd0, 0);    // R7
    issue(1, OP_XPRE, 5'd14, 9'd0, 0);  // R8 legal after read
    issue(1, OP_ACT, 5'd0, 9'd3, 0);
    issue(1, OP_WR, 5'd0, 9'd0, 1);     // R7 masked write
    issue(1, OP_XPRE, 5'd0, 9'd0, 0);   // R8 illegal after masked write
    issue(1, OP_WR, 5'd0, 9'd0, 0);
    issue(0, OP_ACT, 5'd0, 9'd0, 0);    // idle between keeps pairing
    issue(1, OP_XPRE, 5'd0, 9'd0, 0);   // R8 legal
    issue(1, OP_ACT, 5'd0, 9'd3, 0);
    issue(1, OP_WR, 5'd0, 9'd0, 0);
    issue(1, OP_XPRE, 5'd2, 9'd0, 0);   // R8 wrong bank
    issue(1, OP_XPRE, 5'd0, 9'd0, 0);   // R8 not immediately after
    issue(1, OP_RD, 5'd5, 9'd0, 0);     // R7 closed bank
    issue(1, OP_WRA, 5'd5, 9'd0, 0);    // R6 closed bank
    issue(1, OP_RDA, 5'd0, 9'd0, 0);    // R6 closes
    issue(1, OP_ACT, 5'd31, 9'd8, 0);
    issue(1, OP_ACT, 5'd30, 9'd8, 0);   // R3 top edge
    issue(1, OP_PREC, 5'd31, 9'd0, 0);  // R6
    issue(1, OP_ACT, 5'd30, 9'd8, 0);
    issue(1, OP_WRA, 5'd30, 9'd0, 0);   // R6

    for (int i = 0; i < RANDOM_CMDS; i++) begin
      int r = $urandom_range(0, 99);
      logic [2:0] op;
      logic [4:0] b = 5'($urandom_range(0, NB-1));
      if (m_arm && r < 25) begin op = OP_XPRE; b = m_arm_bank; end
      else if (r < 50) op = OP_ACT;
      else op = 3'($urandom_range(0, 7));
      if (r >= 50 && r < 70 && m_open != '0) begin
        for (int k = 0; k < NB; k++) if (m_open[(int'(b) + k) % NB]) begin b = 5'((int'(b) + k) % NB); break; end
      end
      issue($urandom_range(0, 9) != 0, op, b, 9'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule